// File: doc/BRIEF.md
# USB Charging Port Classifier

This block works out what kind of USB port a device has been plugged into. It reads a small set of analog comparator results as plain input bits and steps through a fixed detection sequence. First it confirms that bus power is present. It then waits until the data pins have made steady contact, and then asks whether a charger is present at all. When a charger is present, it pulls DP high and reads the DM level to tell a wall-type dedicated charger from a host port that can also charge.

The sequencer drives the controls of the comparator front end: a detector enable, two mode selects (contact check and charger check) and a DP pull-up request. When a run ends it reports a two-bit port code together with a single-cycle completion pulse. The contact sampling interval and the settle time before each charger read are parameters counted in clock cycles. The contact sample budget and the required run of good samples are also parameters.

Top module: `chg_type_detect`

## Requirements
- R1: A start request accepted while bus power is absent produces a completion pulse in the very next cycle with code 0 (unknown). No control output is raised during that run.
- R2: During contact detection, the detector enable and the contact-check select are high, and both the charger-check select and the DP pull-up are low.
- R3: Contact is sampled once every SAMPLE_GAP cycles. A low sample resets the run of consecutive good samples to zero, and contact is accepted on the sample that brings the run above CONTACT_HITS (the sixth in a row with the default of 5).
- R4: When CONTACT_BUDGET samples pass without accepted contact, the run ends with code 0 and the detector disabled. A contact accepted on the last sample of the budget still counts.
- R5: In the primary phase, the detector enable and charger-check select are high and contact-check is low. After SETTLE_CYC cycles the charger input is read, and a low value ends the run with code 1 (standard port).
- R6: When a charger is seen, the detector is disabled and DP is pulled up for SETTLE_CYC cycles. DM is then read: high gives code 3 (dedicated charger) and low gives code 2 (charging downstream port).
- R7: The DP pull-up is released by the completion cycle and stays low afterwards.
- R8: The completion pulse lasts exactly one cycle. The result output carries the code from that cycle on and holds it until the next completion.
- R9: A start request is acted on only while idle and is ignored in every other phase. While idle, every control output is low.
- R10: Under reset all outputs are low and the result reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a detection run |
| vbus_valid_i | input | 1 | Bus power comparator: power present |
| contact_i | input | 1 | Data-pin contact comparator |
| charger_i | input | 1 | Primary comparator: charger present |
| dm_high_i | input | 1 | Secondary comparator: DM level high |
| det_en_o | output | 1 | Detector front-end enable |
| chk_contact_o | output | 1 | Select contact checking |
| chk_charger_o | output | 1 | Select charger checking |
| dp_pullup_o | output | 1 | Request DP pull-up for the secondary check |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | Port code: 0 unknown, 1 standard, 2 charging downstream, 3 dedicated |

## Verification
The bench goes after the debounce edges. A run of exactly five good samples followed by a miss, repeated, must end in exhaustion with code 0. A design that accepts at five hits would report a port instead. A single miss in the middle of a run must restart the count, and a design that only pauses the count would finish several samples early. Contact that first becomes good on sample 95 must be accepted on the 100th sample, which catches a design that checks the budget ahead of acceptance. The bench also checks the no-power abort, a start request made in the middle of a run, and the charger/DM branches. The completion latency is compared against the cycle count implied by SAMPLE_GAP and SETTLE_CYC, so an off-by-one in any wait shows up.

// File: rtl/chgdet_pkg.sv
package chgdet_pkg;

  typedef enum logic [2:0] {
    PH_IDLE      = 3'd0,
    PH_CONTACT   = 3'd1,
    PH_PRIMARY   = 3'd2,
    PH_SECONDARY = 3'd3,
    PH_REPORT    = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_STD  = 2'd1,
    KIND_CDP  = 2'd2,
    KIND_DCP  = 2'd3
  } kind_e;

  typedef struct packed {
    logic det_en;
    logic chk_contact;
    logic chk_charger;
    logic dp_pullup;
  } pads_t;

  // Front-end control pattern owned by each phase
  function automatic pads_t phase_pads(input phase_e ph);
    pads_t p;
    p = '0;
    case (ph)
      PH_CONTACT: begin
        p.det_en      = 1'b1;
        p.chk_contact = 1'b1;
      end
      PH_PRIMARY: begin
        p.det_en      = 1'b1;
        p.chk_charger = 1'b1;
      end
      PH_SECONDARY: p.dp_pullup = 1'b1;
      default:      p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/chgdet_interval.sv
// Down-counter that paces contact samples and settle waits.
module chgdet_interval #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         run_i,
  output logic         expire_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i | (run_i & (cnt_q != '0));
    cnt_d  = load_i ? load_val_i : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expire_o = run_i & (cnt_q == '0);

endmodule

// File: rtl/chgdet_debounce.sv
// Consecutive-hit counter and sample budget for data-pin contact.
module chgdet_debounce #(
  parameter int BUDGET = 100,
  parameter int HITS   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic sample_i,
  input  logic contact_i,
  output logic accept_o,
  output logic exhaust_o
);

  localparam int HW = $clog2(HITS + 2);
  localparam int SW = $clog2(BUDGET + 1);

  logic [HW-1:0] hits_q, hits_d;
  logic [SW-1:0] samp_q, samp_d;
  logic          upd_en;

  assign accept_o  = sample_i & contact_i & (hits_q == HW'(HITS));
  assign exhaust_o = sample_i & ~accept_o & (samp_q == SW'(BUDGET - 1));

  always_comb begin
    upd_en = clear_i | sample_i;
    if (clear_i) begin
      hits_d = '0;
      samp_d = '0;
    end else begin
      hits_d = contact_i ? (hits_q + 1'b1) : '0;
      samp_d = samp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hits_q <= '0;
      samp_q <= '0;
    end else if (upd_en) begin
      hits_q <= hits_d;
      samp_q <= samp_d;
    end
  end

endmodule

// File: rtl/chgdet_seq.sv
// Phase sequencer: power check, contact, primary, secondary, report.
module chgdet_seq
  import chgdet_pkg::*;
#(
  parameter int SAMPLE_GAP = 4,
  parameter int SETTLE_CYC = 4,
  parameter int TW         = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          vbus_ok_i,
  input  logic          charger_i,
  input  logic          dm_high_i,
  input  logic          expire_i,
  input  logic          accept_i,
  input  logic          exhaust_i,
  output phase_e        phase_o,
  output logic          load_o,
  output logic [TW-1:0] load_val_o,
  output logic [1:0]    result_o,
  output logic          done_o
);

  localparam logic [TW-1:0] GAP_LD = TW'(SAMPLE_GAP - 1);
  localparam logic [TW-1:0] SET_LD = TW'(SETTLE_CYC - 1);

  phase_e ph_q, ph_d;
  kind_e  res_q, res_d;
  logic   res_we;

  always_comb begin
    ph_d       = ph_q;
    res_d      = res_q;
    res_we     = 1'b0;
    load_o     = 1'b0;
    load_val_o = GAP_LD;
    case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          if (!vbus_ok_i) begin
            ph_d   = PH_REPORT;
            res_d  = KIND_NONE;
            res_we = 1'b1;
          end else begin
            ph_d   = PH_CONTACT;
            load_o = 1'b1;
          end
        end
      end
      PH_CONTACT: begin
        if (expire_i) begin
          if (accept_i) begin
            ph_d       = PH_PRIMARY;
            load_o     = 1'b1;
            load_val_o = SET_LD;
          end else if (exhaust_i) begin
            ph_d   = PH_REPORT;
            res_d  = KIND_NONE;
            res_we = 1'b1;
          end else begin
            load_o = 1'b1;
          end
        end
      end
      PH_PRIMARY: begin
        if (expire_i) begin
          if (!charger_i) begin
            ph_d   = PH_REPORT;
            res_d  = KIND_STD;
            res_we = 1'b1;
          end else begin
            ph_d       = PH_SECONDARY;
            load_o     = 1'b1;
            load_val_o = SET_LD;
          end
        end
      end
      PH_SECONDARY: begin
        if (expire_i) begin
          ph_d   = PH_REPORT;
          res_d  = dm_high_i ? KIND_DCP : KIND_CDP;
          res_we = 1'b1;
        end
      end
      PH_REPORT: ph_d = PH_IDLE;
      default:   ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
    end else begin
      ph_q <= ph_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= KIND_NONE;
    end else if (res_we) begin
      res_q <= res_d;
    end
  end

  assign phase_o  = ph_q;
  assign result_o = res_q;
  assign done_o   = (ph_q == PH_REPORT);

endmodule

// File: rtl/chg_type_detect.sv
module chg_type_detect
  import chgdet_pkg::*;
#(
  parameter int SAMPLE_GAP     = 50000,
  parameter int SETTLE_CYC     = 20000,
  parameter int CONTACT_BUDGET = 100,
  parameter int CONTACT_HITS   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       vbus_valid_i,
  input  logic       contact_i,
  input  logic       charger_i,
  input  logic       dm_high_i,
  output logic       det_en_o,
  output logic       chk_contact_o,
  output logic       chk_charger_o,
  output logic       dp_pullup_o,
  output logic       done_o,
  output logic [1:0] result_o
);

  localparam int LONGEST = (SAMPLE_GAP > SETTLE_CYC) ? SAMPLE_GAP : SETTLE_CYC;
  localparam int TW      = (LONGEST > 1) ? $clog2(LONGEST) : 1;

  phase_e        phase;
  pads_t         pads;
  logic          load;
  logic [TW-1:0] load_val;
  logic          run;
  logic          expire;
  logic          sample;
  logic          accept;
  logic          exhaust;

  assign run    = (phase == PH_CONTACT) | (phase == PH_PRIMARY) | (phase == PH_SECONDARY);
  assign sample = expire & (phase == PH_CONTACT);

  chgdet_interval #(.W(TW)) u_interval (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_val_i (load_val),
    .run_i      (run),
    .expire_o   (expire)
  );

  chgdet_debounce #(.BUDGET(CONTACT_BUDGET), .HITS(CONTACT_HITS)) u_debounce (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (phase == PH_IDLE),
    .sample_i  (sample),
    .contact_i (contact_i),
    .accept_o  (accept),
    .exhaust_o (exhaust)
  );

  chgdet_seq #(.SAMPLE_GAP(SAMPLE_GAP), .SETTLE_CYC(SETTLE_CYC), .TW(TW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .vbus_ok_i  (vbus_valid_i),
    .charger_i  (charger_i),
    .dm_high_i  (dm_high_i),
    .expire_i   (expire),
    .accept_i   (accept),
    .exhaust_i  (exhaust),
    .phase_o    (phase),
    .load_o     (load),
    .load_val_o (load_val),
    .result_o   (result_o),
    .done_o     (done_o)
  );

  assign pads          = phase_pads(phase);
  assign det_en_o      = pads.det_en;
  assign chk_contact_o = pads.chk_contact;
  assign chk_charger_o = pads.chk_charger;
  assign dp_pullup_o   = pads.dp_pullup;

endmodule

// File: rtl/chgdet_checker.sv
module chgdet_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       det_en,
  input logic       chk_contact,
  input logic       chk_charger,
  input logic       dp_pullup,
  input logic       done,
  input logic [1:0] result
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_MODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(chk_contact && chk_charger)); // R2

  AST_CHECK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_contact || chk_charger) |-> det_en); // R5

  AST_PULLUP_DETECTOR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    dp_pullup |-> (!det_en && !chk_charger)); // R6

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!det_en && !dp_pullup)); // R7

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result)); // R8

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chk_contact) |-> $past(!det_en && !dp_pullup && !done)); // R9

endmodule

bind chg_type_detect chgdet_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .det_en      (det_en_o),
  .chk_contact (chk_contact_o),
  .chk_charger (chk_charger_o),
  .dp_pullup   (dp_pullup_o),
  .done        (done_o),
  .result      (result_o)
);

// File: tb/chg_type_detect_tb.sv
`timescale 1ns/1ps
module chg_type_detect_tb;

  localparam int GAP    = 3;
  localparam int SETTLE = 4;
  localparam int BUDGET = 100;
  localparam int HITS   = 5;

  logic       clk;
  logic       rst_n;
  logic       start_i, vbus_valid_i, contact_i, charger_i, dm_high_i;
  logic       det_en_o, chk_contact_o, chk_charger_o, dp_pullup_o, done_o;
  logic [1:0] result_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  chg_type_detect #(
    .SAMPLE_GAP(GAP), .SETTLE_CYC(SETTLE),
    .CONTACT_BUDGET(BUDGET), .CONTACT_HITS(HITS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vbus_valid_i(vbus_valid_i),
    .contact_i(contact_i), .charger_i(charger_i), .dm_high_i(dm_high_i),
    .det_en_o(det_en_o), .chk_contact_o(chk_contact_o), .chk_charger_o(chk_charger_o),
    .dp_pullup_o(dp_pullup_o), .done_o(done_o), .result_o(result_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 contact, 2 primary, 3 secondary, 4 report
  int m_ph, m_wait, m_hits, m_samp, m_res;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_wait = 0; m_hits = 0; m_samp = 0; m_res = 0;
    end else begin
      case (m_ph)
        0: if (start_i) begin
             if (!vbus_valid_i) begin m_res = 0; m_ph = 4; end
             else begin m_ph = 1; m_wait = GAP; m_hits = 0; m_samp = 0; end
           end
        1: begin
             m_wait = m_wait - 1;
             if (m_wait == 0) begin
               m_samp = m_samp + 1;
               m_hits = contact_i ? m_hits + 1 : 0;
               if (m_hits > HITS) begin m_ph = 2; m_wait = SETTLE; end
               else if (m_samp == BUDGET) begin m_res = 0; m_ph = 4; end
               else m_wait = GAP;
             end
           end
        2: begin
             m_wait = m_wait - 1;
             if (m_wait == 0) begin
               if (!charger_i) begin m_res = 1; m_ph = 4; end
               else begin m_ph = 3; m_wait = SETTLE; end
             end
           end
        3: begin
             m_wait = m_wait - 1;
             if (m_wait == 0) begin m_res = dm_high_i ? 3 : 2; m_ph = 4; end
           end
        default: m_ph = 0;
      endcase
    end
  end

  // Compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int exp_ctl, act_ctl;
      string rq;
      exp_ctl = {m_ph == 1 || m_ph == 2, m_ph == 1, m_ph == 2, m_ph == 3};
      act_ctl = {det_en_o, chk_contact_o, chk_charger_o, dp_pullup_o};
      case (m_ph)
        1: rq = "R2";
        2: rq = "R5";
        3: rq = "R6";
        4: rq = "R7";
        default: rq = "R9";
      endcase
      check(act_ctl == exp_ctl, rq, "controls{en,contact,charger,pullup}", act_ctl, exp_ctl);
      check(int'(done_o) == int'(m_ph == 4), "R8", "done_o", done_o, m_ph == 4);
      check(int'(result_o) == m_res, "R8", "result_o", result_o, m_res);
    end
  end

  function automatic logic pat(input int kind, input int n);
    case (kind)
      0: return 1'b1;
      1: return (n != 15);
      2: return 1'b0;
      3: return (n >= 283);
      default: return (((n + 2) / 3) % 6) != 0;
    endcase
  endfunction

  task automatic run_case(input logic vb, input logic cg, input logic dm,
                          input int kind, input bit poke, input int exp_code,
                          input int exp_lat, input string req);
    int n;
    bit seen;
    @(negedge clk);
    vbus_valid_i = vb; charger_i = cg; dm_high_i = dm;
    contact_i = pat(kind, 0);
    start_i = 1'b1;
    n = 0; seen = 0;
    while (!seen && n < 2000) begin
      @(negedge clk);
      n++;
      if (done_o) seen = 1;
      start_i   = poke && (n == 10);
      contact_i = pat(kind, n);
    end
    check(n == exp_lat, req, "cycles start->done", n, exp_lat);
    check(int'(result_o) == exp_code, req, "code at done", result_o, exp_code);
    repeat (4) @(negedge clk);
    check(int'(result_o) == exp_code && !done_o, "R8", "code held after done", result_o, exp_code);
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 0; vbus_valid_i = 0; contact_i = 0; charger_i = 0; dm_high_i = 0;
    repeat (3) @(negedge clk);
    check({det_en_o, chk_contact_o, chk_charger_o, dp_pullup_o, done_o, result_o} == 0,
          "R10", "outputs in reset",
          {det_en_o, chk_contact_o, chk_charger_o, dp_pullup_o, done_o, result_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: no bus power
    run_case(1'b0, 1'b1, 1'b1, 0, 0, 0, 1, "R1");
    // R5: clean contact, no charger
    run_case(1'b1, 1'b0, 1'b0, 0, 0, 1, (HITS + 1) * GAP + SETTLE + 1, "R5");
    // R3: miss on sample 5 restarts the run; DM high gives dedicated
    run_case(1'b1, 1'b1, 1'b1, 1, 0, 3, 11 * GAP + 2 * SETTLE + 1, "R3");
    // R3: runs of exactly five hits never accept
    run_case(1'b1, 1'b0, 1'b0, 4, 0, 0, BUDGET * GAP + 1, "R3");
    // R4: no contact at all
    run_case(1'b1, 1'b1, 1'b1, 2, 0, 0, BUDGET * GAP + 1, "R4");
    // R4: acceptance on the last sample of the budget; DM low gives CDP
    run_case(1'b1, 1'b1, 1'b0, 3, 0, 2, BUDGET * GAP + 2 * SETTLE + 1, "R4");
    // R6: charging downstream port, start poked mid-run (R9)
    run_case(1'b1, 1'b1, 1'b0, 0, 1, 2, (HITS + 1) * GAP + 2 * SETTLE + 1, "R9");
    // R6: dedicated charger
    run_case(1'b1, 1'b1, 1'b1, 0, 0, 3, (HITS + 1) * GAP + 2 * SETTLE + 1, "R6");
    // R7: pull-up stays released while idle
    repeat (5) @(negedge clk);
    check(!dp_pullup_o, "R7", "pull-up after run", dp_pullup_o, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule